// File: doc/BRIEF.md
# Shunt Current, Power and Energy Datapath

This block turns per-channel measurement results into derived quantities. Each time a result-valid strobe arrives with a channel index, a signed shunt-voltage sample and an unsigned bus-voltage sample, the block does two things for that channel:

- It multiplies the shunt sample by the channel's calibration value, scales the product down and clamps it into a 16-bit two's-complement current.
- It multiplies the magnitude of that current by the bus voltage, scales the product down and clamps it into a 16-bit unsigned power.

Both products are combinational. The two results are registered together.

A timebase tick adds every channel's held power value into that channel's energy accumulator. A wrap of an accumulator raises a sticky flag for that channel. A per-channel clear pulse zeroes one accumulator and its flag. A single sticky math-overflow flag records that a current or power result was ever clamped.

Top module: `pwr_energy_calc`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), all currents, powers, energy totals, energy-overflow flags and the math-overflow flag are zero.
- R2: When `res_valid_i` is high, the clock edge writes a current to channel `res_ch_i`. The current is floor((shunt × cal) / 2^CSHIFT), where shunt is `shunt_i` read as signed and cal is that channel's unsigned CAL_W-bit field `cal_i[ch*CAL_W +: CAL_W]`. The current of every other channel is unchanged.
- R3: A current above 32767 is stored as 32767 (0x7FFF), and a current below -32768 is stored as -32768 (0x8000).
- R4: The same edge writes a power to that channel. The power is floor((|current| × bus) / 2^PSHIFT), where current is the value written at that edge and bus is `bus_i` read as unsigned. A power above 65535 is stored as 65535.
- R5: `math_ovf_o` goes high one cycle after a strobe whose current or power was clamped. It then stays high until reset.
- R6: On a clock edge with `tick_i` high, each channel whose clear bit is low adds the power it held before that edge to its EW-bit energy total, modulo 2^EW. Without a tick, the energy totals hold.
- R7: When the energy addition of channel k wraps past 2^EW, `eovf_o[k]` goes high and stays high until that channel is cleared or the block is reset.
- R8: `clr_i[k]` high at an edge zeroes energy total k and `eovf_o[k]`. This happens even when `tick_i` is high in the same cycle. Other channels are not affected.
- R9: With `res_valid_i` low, all currents and powers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| res_valid_i | input | 1 | New shunt/bus result present |
| res_ch_i | input | $clog2(NCH) | Channel of the result |
| shunt_i | input | 16 | Shunt-voltage result, two's complement |
| bus_i | input | 16 | Bus-voltage result, unsigned |
| cal_i | input | NCH*CAL_W | Calibration field per channel, channel k at bits k*CAL_W |
| tick_i | input | 1 | Energy timebase tick |
| clr_i | input | NCH | Per-channel energy and overflow clear pulse |
| cur_o | output | NCH*16 | Currents, channel k at bits 16k |
| pwr_o | output | NCH*16 | Powers, channel k at bits 16k |
| energy_o | output | NCH*EW | Energy totals, channel k at bits k*EW |
| eovf_o | output | NCH | Sticky energy-overflow flags |
| math_ovf_o | output | 1 | Sticky current/power clamp flag |

## Verification
The bench builds the block with NCH=4, CAL_W=15, EW=20, CSHIFT=2 and PSHIFT=8.

The narrow 20-bit accumulator lets a channel held at full-scale power wrap within about sixteen ticks. This brings the energy-overflow flag and its clear within a short run.

The small current shift lets ordinary shunt and calibration values drive the current into both clamp limits. The 8-bit power shift keeps mid-range products unclamped, while full-scale bus values still reach the power clamp.

// File: rtl/pwr_energy_calc.sv
module pwr_energy_calc #(
  parameter int NCH    = 4,
  parameter int CAL_W  = 15,
  parameter int EW     = 32,
  parameter int CSHIFT = 8,
  parameter int PSHIFT = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   res_valid_i,
  input  logic [$clog2(NCH)-1:0] res_ch_i,
  input  logic [15:0]            shunt_i,
  input  logic [15:0]            bus_i,
  input  logic [NCH*CAL_W-1:0]   cal_i,
  input  logic                   tick_i,
  input  logic [NCH-1:0]         clr_i,
  output logic [NCH*16-1:0]      cur_o,
  output logic [NCH*16-1:0]      pwr_o,
  output logic [NCH*EW-1:0]      energy_o,
  output logic [NCH-1:0]         eovf_o,
  output logic                   math_ovf_o
);
  localparam int PW = 16 + CAL_W + 1;
  localparam logic signed [PW-1:0] CMAX = PW'(32767);
  localparam logic signed [PW-1:0] CMIN = -PW'(32768);

  logic [CAL_W-1:0]     cal_sel;
  logic signed [PW-1:0] cprod, cshf;
  logic                 cur_hi, cur_lo, p_sat;
  logic [15:0]          cur_new, pwr_new;
  logic [16:0]          cur_abs;
  logic [32:0]          pprod, pshf;

  logic [15:0]   cur_q [NCH];
  logic [15:0]   pwr_q [NCH];
  logic [EW-1:0] en_q  [NCH];
  logic [NCH-1:0] eovf_q;
  logic           movf_q;

  assign cal_sel = cal_i[res_ch_i*CAL_W +: CAL_W];
  assign cprod   = $signed(shunt_i) * $signed({1'b0, cal_sel});
  assign cshf    = cprod >>> CSHIFT;
  assign cur_hi  = cshf > CMAX;
  assign cur_lo  = cshf < CMIN;
  assign cur_new = cur_hi ? 16'h7fff : cur_lo ? 16'h8000 : cshf[15:0];
  assign cur_abs = cur_new[15] ? 17'd0 - {1'b1, cur_new} : {1'b0, cur_new};
  assign pprod   = cur_abs * bus_i;
  assign pshf    = pprod >> PSHIFT;
  assign p_sat   = |pshf[32:16];
  assign pwr_new = p_sat ? 16'hffff : pshf[15:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < NCH; k++) begin
        cur_q[k] <= '0;
        pwr_q[k] <= '0;
      end
      movf_q <= 1'b0;
    end else if (res_valid_i) begin
      cur_q[res_ch_i] <= cur_new;
      pwr_q[res_ch_i] <= pwr_new;
      if (cur_hi || cur_lo || p_sat) movf_q <= 1'b1;
    end
  end

  assign math_ovf_o = movf_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [EW:0] sum;
    assign sum = {1'b0, en_q[g]} + (EW+1)'(pwr_q[g]);

    always_ff @(posedge clk_i) begin
      if (rst_i || clr_i[g]) begin
        en_q[g]   <= '0;
        eovf_q[g] <= 1'b0;
      end else if (tick_i) begin
        en_q[g] <= sum[EW-1:0];
        if (sum[EW]) eovf_q[g] <= 1'b1;
      end
    end

    assign cur_o[g*16 +: 16]    = cur_q[g];
    assign pwr_o[g*16 +: 16]    = pwr_q[g];
    assign energy_o[g*EW +: EW] = en_q[g];
    assign eovf_o[g]            = eovf_q[g];

    assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i[g] |=> (energy_o[g*EW +: EW] == '0) && !eovf_o[g]);
    assert_eovf_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (eovf_o[g] && !clr_i[g]) |=> eovf_o[g]);
    assert_energy_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!tick_i && !clr_i[g]) |=> $stable(energy_o[g*EW +: EW]));
  end

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !res_valid_i |=> ($stable(cur_o) && $stable(pwr_o)));
  assert_movf_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    math_ovf_o |=> math_ovf_o);
  assert_sat_flags_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (res_valid_i && (cur_hi || cur_lo)) |=> math_ovf_o);
endmodule

// File: tb/pwr_energy_calc_tb.sv
module pwr_energy_calc_tb_top;
  localparam int NCH = 4, CW = 15, EW = 20, CS = 2, PS = 8;
  localparam longint EMOD = longint'(1) << EW;

  logic clk = 0, rst = 1;
  logic valid = 0, tick = 0;
  logic [1:0] ch = 0;
  logic signed [15:0] shunt = 0;
  logic [15:0] bus = 0;
  logic [NCH*CW-1:0] cal = 0;
  logic [NCH-1:0] clr = 0;
  logic [NCH*16-1:0] cur, pwr;
  logic [NCH*EW-1:0] en;
  logic [NCH-1:0] eovf;
  logic movf;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  longint mc[NCH], mp[NCH], me[NCH];
  bit meo[NCH];
  bit mov;

  always #2 clk = ~clk;

  pwr_energy_calc #(.NCH(NCH), .CAL_W(CW), .EW(EW), .CSHIFT(CS), .PSHIFT(PS)) dut_i (
    .clk_i(clk), .rst_i(rst), .res_valid_i(valid), .res_ch_i(ch), .shunt_i(shunt),
    .bus_i(bus), .cal_i(cal), .tick_i(tick), .clr_i(clr), .cur_o(cur), .pwr_o(pwr),
    .energy_o(en), .eovf_o(eovf), .math_ovf_o(movf));

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    longint c, a, p;
    cyc++;
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin mc[k] = 0; mp[k] = 0; me[k] = 0; meo[k] = 0; end
      mov = 0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (clr[k]) begin me[k] = 0; meo[k] = 0; end
        else if (tick) begin
          me[k] += mp[k];
          if (me[k] >= EMOD) begin me[k] -= EMOD; meo[k] = 1; end
        end
      end
      if (valid) begin
        c = longint'(shunt) * longint'(cal[ch*CW +: CW]);
        c = c >>> CS;
        if (c > 32767) begin c = 32767; mov = 1; end
        else if (c < -32768) begin c = -32768; mov = 1; end
        mc[ch] = c;
        a = (c < 0) ? -c : c;
        p = (a * longint'(bus)) >>> PS;
        if (p > 65535) begin p = 65535; mov = 1; end
        mp[ch] = p;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < NCH; k++) begin
        chk(cur[k*16 +: 16] == 16'(mc[k]), "R2/R3 current", longint'(cur[k*16 +: 16]), mc[k] & 'hffff);
        chk(pwr[k*16 +: 16] == 16'(mp[k]), "R4 power", longint'(pwr[k*16 +: 16]), mp[k]);
        chk(en[k*EW +: EW] == EW'(me[k]), "R6/R8 energy", longint'(en[k*EW +: EW]), me[k]);
        chk(eovf[k] == meo[k], "R7/R8 energy overflow", longint'(eovf[k]), longint'(meo[k]));
      end
      chk(movf == mov, "R5 math overflow", longint'(movf), longint'(mov));
    end
  end

  task automatic step(bit v, int c, int sh, int b, bit t, logic [NCH-1:0] cl);
    @(posedge clk); #1;
    valid = v; ch = 2'(c); shunt = 16'(sh); bus = 16'(b); tick = t; clr = cl;
  endtask

  initial begin
    cal = {15'h7fff, 15'd1, 15'd50, 15'd50};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(cur == '0 && pwr == '0 && en == '0 && eovf == '0 && !movf, "R1 reset state",
        longint'(|{cur, pwr, en, eovf, movf}), 0);
    step(1, 0, 100, 1000, 0, 0);
    step(1, 1, -100, 1000, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 2, 7, 9, 0, 0);
    repeat (5) step(0, 0, 0, 0, 1, 0);
    step(1, 2, -32768, 40000, 0, 0);
    step(1, 3, 32767, 65535, 0, 0);
    step(1, 3, -32768, 65535, 1, 0);
    repeat (20) step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 4'b1000);
    step(0, 0, 0, 0, 1, 4'b0001);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) cal = {$urandom, $urandom};
      step(($urandom % 3) != 0, $urandom % 4, $urandom, $urandom, ($urandom % 2) == 0,
           (($urandom % 16) == 0) ? 4'($urandom) : 4'b0);
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=finished", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule